// File: doc/BRIEF.md
# Strap-Configured Dual Clock Source Selector and Divider

This block produces two derived clocks, one for a processor domain and one for a bus domain. Each output picks one of four free-running, mutually asynchronous source clocks (main, user, PLL, crystal). It then divides that source by 1, 2, 4 or 8. A 4-bit code per output sets both choices. Bits 1:0 of the code select the source and bits 3:2 select the divide ratio.

After reset both codes load from a 4-bit strap input. Software can later write new codes through an 8-bit control port and read the codes that are in effect. A new code goes through a break-before-make handshake. The running source is gated off on its own falling edge and the divider is cleared. Only then is the new code adopted and the new source gated on, on its own falling edges. Each output switches on its own, so the other output keeps running.

Top module: `clk_strap_div`

## Requirements
- R1: Source code bits 1:0 select the output source as 0 = clk_main, 1 = clk_user, 2 = clk_pll, 3 = clk_xtal. The output period equals the selected source period times the divide ratio.
- R2: Divide code bits 3:2 give ratios 0 = /1, 1 = /2, 2 = /4, 3 = /8. Divided outputs have a 50% duty cycle.
- R3: With divide code 0, the output follows the selected source directly: same period and same high time.
- R4: The processor output and the bus output are configured independently. Writing a new code for one leaves the other output's period unchanged.
- R5: On the first clk_main edge after reset release, both codes load from strap_cfg. ctrl_rdata shows the processor code in bits 7:4 and the bus code in bits 3:0. ctrl_rdata changes only while a channel is loading or switching.
- R6: Source changes are glitch-free. At most one source is gated onto a channel at any time. A newly enabled source starts only after every source of that channel was off. No output phase after reset is shorter than half the fastest source period.
- R7: A write to ctrl_wdata with ctrl_we set does not change ctrl_rdata on the following cycle. A channel's nibble in ctrl_rdata changes only after its old source has been observed off for SETTLE clk_main cycles.
- R8: When a channel's new code first appears in ctrl_rdata, that channel's output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_main | input | 1 | Main source clock; also clocks the control logic |
| clk_user | input | 1 | Second user source clock |
| clk_pll | input | 1 | PLL source clock |
| clk_xtal | input | 1 | Crystal source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_cfg | input | 4 | Code loaded into both channels after reset |
| ctrl_we | input | 1 | Write strobe for ctrl_wdata, sampled on clk_main |
| ctrl_wdata | input | 8 | New codes: processor in 7:4, bus in 3:0 |
| ctrl_rdata | output | 8 | Codes in effect: processor in 7:4, bus in 3:0 |
| cpu_clk_out | output | 1 | Derived processor-domain clock |
| bus_clk_out | output | 1 | Derived bus-domain clock |

## Verification
Suppose the enable handshake for a source is wrong, for example two enables overlap or a new source starts before the old one stopped. This shows at the outputs as a high or low phase shorter than any source half-period, within one source cycle of the switch. A wrong divide counter or source decode shows at once as a wrong period or a wrong high time on the next few output cycles. A code adopted too early is visible as a change in ctrl_rdata in the cycle after the write, or as a channel output that is still high when its new code appears.

// File: rtl/clk_strap_div.sv
module clk_strap_div #(
  parameter int SETTLE = 4
) (
  input  logic       clk_main,
  input  logic       clk_user,
  input  logic       clk_pll,
  input  logic       clk_xtal,
  input  logic       rst_n,
  input  logic [3:0] strap_cfg,
  input  logic       ctrl_we,
  input  logic [7:0] ctrl_wdata,
  output logic [7:0] ctrl_rdata,
  output logic       cpu_clk_out,
  output logic       bus_clk_out
);
  localparam int SW = $clog2(SETTLE + 1);
  localparam logic [1:0] S_LOAD = 2'd0, S_RUN = 2'd1, S_DRAIN = 2'd2;

  logic [3:0] srcs;
  logic [1:0] st_a  [2];
  logic [3:0] en_a  [2];
  logic [3:0] act_a [2];
  logic       off_a [2];
  logic       out_a [2];

  assign srcs = {clk_xtal, clk_pll, clk_user, clk_main};

  for (genvar c = 0; c < 2; c++) begin : g_ch
    logic [1:0]    st;
    logic [3:0]    act, pend, en_v, busy_v, nib;
    logic [SW-1:0] dcnt;
    logic          off_m, off_s, clr_q, run, mclk, o;
    logic [2:0]    cnt;

    assign nib = ctrl_wdata[7-4*c -: 4];
    assign run = (st == S_RUN);

    for (genvar s = 0; s < 4; s++) begin : g_src
      logic meta, en, req;
      assign req = run && (act[1:0] == 2'(s)) && ((en_v & ~(4'b1 << s)) == 4'b0);
      always_ff @(negedge srcs[s] or negedge rst_n)
        if (!rst_n) begin
          meta <= 1'b0;
          en   <= 1'b0;
        end else begin
          meta <= req;
          en   <= meta;
        end
      assign en_v[s]   = en;
      assign busy_v[s] = en | meta;
    end

    always_ff @(posedge clk_main or negedge rst_n)
      if (!rst_n) begin
        off_m <= 1'b0;
        off_s <= 1'b0;
      end else begin
        off_m <= ~|busy_v;
        off_s <= off_m;
      end

    always_ff @(posedge clk_main or negedge rst_n)
      if (!rst_n) begin
        st    <= S_LOAD;
        act   <= '0;
        pend  <= '0;
        dcnt  <= '0;
        clr_q <= 1'b1;
      end else begin
        clr_q <= (st == S_LOAD) || (st == S_DRAIN && off_s);
        if (ctrl_we) pend <= nib;
        case (st)
          S_LOAD: begin
            act  <= strap_cfg;
            pend <= strap_cfg;
            st   <= S_RUN;
          end
          S_RUN: if (pend != act) begin
            st   <= S_DRAIN;
            dcnt <= '0;
          end
          default: begin
            if (!off_s) dcnt <= '0;
            else if (dcnt == SW'(SETTLE - 1)) begin
              act <= pend;
              st  <= S_RUN;
            end else dcnt <= dcnt + 1'b1;
          end
        endcase
      end

    assign mclk = |(srcs & en_v);

    always_ff @(posedge mclk or posedge clr_q)
      if (clr_q) cnt <= '0;
      else       cnt <= cnt + 3'd1;

    always_comb
      case (act[3:2])
        2'd0:    o = mclk;
        2'd1:    o = cnt[0];
        2'd2:    o = cnt[1];
        default: o = cnt[2];
      endcase

    assign st_a[c]  = st;
    assign en_a[c]  = en_v;
    assign act_a[c] = act;
    assign off_a[c] = off_s;
    assign out_a[c] = o;
  end

  assign ctrl_rdata  = {act_a[0], act_a[1]};
  assign cpu_clk_out = out_a[0];
  assign bus_clk_out = out_a[1];
endmodule

module clk_strap_div_chk (
  input logic       clk_main,
  input logic       rst_n,
  input logic [7:0] ctrl_rdata,
  input logic [1:0] st0,
  input logic [1:0] st1,
  input logic [3:0] en0,
  input logic [3:0] en1,
  input logic [3:0] act0,
  input logic [3:0] act1,
  input logic       off0,
  input logic       off1
);
  localparam logic [1:0] S_LOAD = 2'd0, S_RUN = 2'd1, S_DRAIN = 2'd2;

  p_one_source_r6: assert property (@(posedge clk_main) disable iff (!rst_n)
    $onehot0(en0) && $onehot0(en1));

  p_start_idle_cpu_r6: assert property (@(posedge clk_main) disable iff (!rst_n)
    (st0 == S_RUN && $past(st0) != S_RUN) |-> (en0 == 4'b0));

  p_start_idle_bus_r6: assert property (@(posedge clk_main) disable iff (!rst_n)
    (st1 == S_RUN && $past(st1) != S_RUN) |-> (en1 == 4'b0));

  p_hold_cpu_r7: assert property (@(posedge clk_main) disable iff (!rst_n)
    (st0 == S_DRAIN && !off0) |=> $stable(act0));

  p_hold_bus_r7: assert property (@(posedge clk_main) disable iff (!rst_n)
    (st1 == S_DRAIN && !off1) |=> $stable(act1));

  p_view_moves_r5: assert property (@(posedge clk_main) disable iff (!rst_n)
    !$stable(ctrl_rdata) |-> ($past(st0) != S_RUN || $past(st1) != S_RUN));

  p_load_once_r5: assert property (@(posedge clk_main) disable iff (!rst_n)
    (st0 == S_LOAD) |=> (st0 == S_RUN));
endmodule

bind clk_strap_div clk_strap_div_chk i_chk (
  .clk_main  (clk_main),
  .rst_n     (rst_n),
  .ctrl_rdata(ctrl_rdata),
  .st0       (st_a[0]),
  .st1       (st_a[1]),
  .en0       (en_a[0]),
  .en1       (en_a[1]),
  .act0      (act_a[0]),
  .act1      (act_a[1]),
  .off0      (off_a[0]),
  .off1      (off_a[1])
);

// File: tb/test_clk_strap_div.sv
`timescale 1ns/1ps
module test_clk_strap_div;
  logic clk_main = 0, clk_user = 0, clk_pll = 0, clk_xtal = 0;
  logic rst_n = 0;
  logic [3:0] strap_cfg = '0;
  logic ctrl_we = 0;
  logic [7:0] ctrl_wdata = '0;
  logic [7:0] ctrl_rdata;
  logic cpu_clk_out, bus_clk_out;

  int checks = 0, fails = 0;
  bit done = 0;
  bit mon_on = 0;
  realtime last_c = 0, last_b = 0, min_c = 1e9, min_b = 1e9;

  always #2.5 clk_main = ~clk_main;
  always #4   clk_user = ~clk_user;
  always #3   clk_pll  = ~clk_pll;
  always #7   clk_xtal = ~clk_xtal;

  clk_strap_div i_clk_strap_div (
    .clk_main(clk_main), .clk_user(clk_user), .clk_pll(clk_pll), .clk_xtal(clk_xtal),
    .rst_n(rst_n), .strap_cfg(strap_cfg), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .ctrl_rdata(ctrl_rdata), .cpu_clk_out(cpu_clk_out), .bus_clk_out(bus_clk_out));

  always @(cpu_clk_out) if (mon_on) begin
    if (last_c > 0 && ($realtime - last_c) < min_c) min_c = $realtime - last_c;
    last_c = $realtime;
  end
  always @(bus_clk_out) if (mon_on) begin
    if (last_b > 0 && ($realtime - last_b) < min_b) min_b = $realtime - last_b;
    last_b = $realtime;
  end

  function automatic real exp_per(input logic [3:0] n);
    real b;
    case (n[1:0])
      2'd0: b = 5.0;
      2'd1: b = 8.0;
      2'd2: b = 6.0;
      default: b = 14.0;
    endcase
    return b * (1 << n[3:2]);
  endfunction

  task automatic chk_r(input string tag, input real act, input real exp);
    checks++;
    if (act < exp - 0.05 || act > exp + 0.05) begin
      fails++;
      $display("FAIL %s: got %0.3f expected %0.3f", tag, act, exp);
    end
  endtask

  task automatic chk_v(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wpos(input bit ch);
    if (ch) @(posedge bus_clk_out); else @(posedge cpu_clk_out);
  endtask
  task automatic wneg(input bit ch);
    if (ch) @(negedge bus_clk_out); else @(negedge cpu_clk_out);
  endtask

  task automatic meas(input bit ch, input logic [3:0] n, input string tag);
    realtime t0, hi, t1;
    wpos(ch); t0 = $realtime;
    wneg(ch); hi = $realtime - t0;
    repeat (4) wpos(ch);
    t1 = $realtime;
    chk_r({tag, " period (R1 R2)"}, (t1 - t0) / 4.0, exp_per(n));
    chk_r({tag, (n[3:2] == 0) ? " high time (R3)" : " duty (R2)"}, hi, exp_per(n) / 2.0);
  endtask

  task automatic do_reset(input logic [3:0] s);
    mon_on = 0;
    @(negedge clk_main);
    rst_n = 0;
    strap_cfg = s;
    repeat (3) @(negedge clk_main);
    rst_n = 1;
    repeat (3) @(negedge clk_main);
    last_c = 0; last_b = 0;
    mon_on = 1;
  endtask

  task automatic reconfig(input logic [7:0] v, input string tag);
    logic [7:0] old;
    bit dc, db;
    int n;
    old = ctrl_rdata;
    @(negedge clk_main);
    ctrl_we = 1; ctrl_wdata = v;
    @(negedge clk_main);
    ctrl_we = 0;
    @(negedge clk_main);
    chk_v({tag, " not yet applied (R7)"}, ctrl_rdata, old);
    dc = (v[7:4] == old[7:4]);
    db = (v[3:0] == old[3:0]);
    n = 0;
    while (!(dc && db) && n < 3000) begin
      @(negedge clk_main);
      n++;
      if (!dc && ctrl_rdata[7:4] == v[7:4]) begin
        dc = 1;
        chk_v({tag, " cpu low at switch end (R8)"}, cpu_clk_out, 0);
      end
      if (!db && ctrl_rdata[3:0] == v[3:0]) begin
        db = 1;
        chk_v({tag, " bus low at switch end (R8)"}, bus_clk_out, 0);
      end
    end
    chk_v({tag, " readback after switch (R5 R7)"}, ctrl_rdata, v);
    repeat (40) @(negedge clk_main);
  endtask

  initial begin
    repeat (150000) @(posedge clk_main);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    repeat (2) @(negedge clk_main);
    checks++;
    if (cpu_clk_out !== 1'b0 || bus_clk_out !== 1'b0) begin
      fails++;
      $display("FAIL reset outputs (R6): got %b%b expected 00", cpu_clk_out, bus_clk_out);
    end

    for (int s = 0; s < 16; s++) begin
      do_reset(4'(s));
      chk_v("strap load into both nibbles (R5)", ctrl_rdata, {4'(s), 4'(s)});
      repeat (40) @(negedge clk_main);
      meas(0, 4'(s), "strap cpu");
      meas(1, 4'(s), "strap bus");
    end

    do_reset(4'd0);
    repeat (20) @(negedge clk_main);
    for (int v = 1; v < 16; v++) begin
      reconfig({4'(v), 4'(15 - v)}, "sweep");
      meas(0, 4'(v), "sweep cpu");
      meas(1, 4'(15 - v), "sweep bus");
    end
    reconfig(8'h26, "sweep");
    meas(0, 4'h2, "sweep cpu");
    meas(1, 4'h6, "sweep bus");

    reconfig(8'hD6, "R4 cpu only");
    meas(1, 4'h6, "R4 bus untouched");
    meas(0, 4'hD, "R4 cpu new");
    reconfig(8'hD1, "R4 bus only");
    meas(0, 4'hD, "R4 cpu untouched");
    meas(1, 4'h1, "R4 bus new");

    checks++;
    if (min_c < 2.49) begin
      fails++;
      $display("FAIL R6 cpu shortest phase: got %0.3f expected >= 2.5", min_c);
    end
    checks++;
    if (min_b < 2.49) begin
      fails++;
      $display("FAIL R6 bus shortest phase: got %0.3f expected >= 2.5", min_b);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule